// File: doc/BRIEF.md
# Vertical Timing and Cursor Register Bank for a Raster Display Controller

This block is the programmable register bank of a character/graphics raster display controller. Software reaches it through one narrow bus with two ports: an index port that selects one of twenty-five 8-bit registers, and a data port that reads or writes the selected register. The block holds the register contents. From them it builds the wide vertical timing values, the two 16-bit memory addresses and the cursor shape fields. These are driven as parallel outputs to the timing generator and the address generator that sit beside it.

Two control behaviours live in one control register at index 0x11. Its bit 7 write-protects the eight lowest registers. Even while that protection is on, the line-compare bit 8 held in the overflow register can still be written. The same control register owns the vertical-retrace interrupt. A rising edge on the retrace input latches a pending flag. Bit 5 masks the interrupt output. Any write to the register with bit 4 low clears the flag.

Top module: `crtc_regbank`

## Requirements
- R1: With `bus_sel` = 0, a write stores `bus_wdata` as the 8-bit index, and a read returns the stored index unchanged for all 256 values.
- R2: With `bus_sel` = 1, a write updates the register chosen by the index (0x00 to 0x18), and a read returns that register's contents.
- R3: Data-port writes while the index is 0x19 or above change no register, and data-port reads at such an index return 0x00.
- R4: While bit 7 of register 0x11 is 1, data writes to indices 0x00 to 0x07 are ignored, except that bit 4 of register 0x07 still takes the written bit. Writes to all other indices, 0x11 included, still take effect.
- R5: `vert_total` = {r07[5], r07[0], r06}; `vert_disp_end` = {r07[6], r07[1], r12}; `vert_rtr_start` = {r07[7], r07[2], r10}, where rNN is the register at hex index NN.
- R6: `line_cmp` = {r09[6], r07[4], r18}; `vert_blank_start` = {r09[5], r07[3], r15}.
- R7: `disp_start` = {r0C, r0D} and `cursor_addr` = {r0E, r0F}.
- R8: `cursor_first` = r0A[4:0], `cursor_off` = r0A[5], `cursor_last` = r0B[4:0], `cursor_skew` = r0B[6:5].
- R9: A low-to-high transition of `vretrace_in`, sampled on the clock, sets a pending flag one clock later. A level held high sets nothing more. `vr_irq` = pending AND NOT r11[5], so a masked pending flag shows up as soon as the mask bit is cleared.
- R10: A data write to index 0x11 with bit 4 = 0 clears the pending flag, and this wins over a retrace edge in the same cycle. A write with bit 4 = 1 leaves the flag as it is.
- R11: After reset, the index, all registers and the pending flag are 0, so write protection is off and `vr_irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| bus_we | input | 1 | Write strobe for the selected port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected port (combinational) |
| vretrace_in | input | 1 | Vertical retrace level from the timing generator |
| vr_irq | output | 1 | Vertical-retrace interrupt request |
| vert_total | output | 10 | Assembled vertical total |
| vert_disp_end | output | 10 | Assembled vertical display end |
| vert_rtr_start | output | 10 | Assembled vertical retrace start |
| vert_blank_start | output | 10 | Assembled vertical blank start |
| line_cmp | output | 10 | Assembled line-compare (split) value |
| disp_start | output | 16 | Display start address |
| cursor_addr | output | 16 | Cursor address |
| cursor_first | output | 5 | First cursor scan line |
| cursor_last | output | 5 | Last cursor scan line |
| cursor_off | output | 1 | Cursor disable |
| cursor_skew | output | 2 | Cursor skew in character clocks |

## Verification
The hardest cases to reach are those where two control paths meet in a single cycle. One is a protected write to the overflow register, where one bit must land and seven must not. The other is a retrace edge that arrives in the same clock as a clearing write to the control register. The bench reaches the first by loading known overflow contents, turning protection on and writing a byte whose bit 4 differs from the stored one. It reaches the second by setting the index to 0x11 first, then raising `vretrace_in` and the clearing data write on the same clock. It also holds the retrace level high across a clear to show that a level does not re-arm the flag. It sweeps all 256 overflow values against varying partner registers to cover every bit of the stitched fields.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  localparam int unsigned CRTC_DW   = 8;
  localparam int unsigned CRTC_NREG = 25;

  localparam int unsigned IX_VTOT      = 'h06;
  localparam int unsigned IX_OVF       = 'h07;
  localparam int unsigned IX_MSL       = 'h09;
  localparam int unsigned IX_CSHAPE_A  = 'h0A;
  localparam int unsigned IX_CSHAPE_B  = 'h0B;
  localparam int unsigned IX_SADDR_HI  = 'h0C;
  localparam int unsigned IX_SADDR_LO  = 'h0D;
  localparam int unsigned IX_CADDR_HI  = 'h0E;
  localparam int unsigned IX_CADDR_LO  = 'h0F;
  localparam int unsigned IX_VRS       = 'h10;
  localparam int unsigned IX_VCTL      = 'h11;
  localparam int unsigned IX_VDE       = 'h12;
  localparam int unsigned IX_VBS       = 'h15;
  localparam int unsigned IX_LCMP      = 'h18;
  localparam int unsigned IX_PROT_LAST = 'h07;

  localparam int unsigned VCTL_CLR_BIT  = 4;
  localparam int unsigned VCTL_MASK_BIT = 5;
  localparam int unsigned VCTL_PROT_BIT = 7;

  typedef struct packed {
    logic [CRTC_DW+1:0] vtot;
    logic [CRTC_DW+1:0] vde;
    logic [CRTC_DW+1:0] vrs;
    logic [CRTC_DW+1:0] vbs;
    logic [CRTC_DW+1:0] lcmp;
  } crtc_vwide_t;
endpackage

// File: rtl/crtc_reg_store.sv
module crtc_reg_store
  import crtc_pkg::*;
#(
  parameter int unsigned NREG = CRTC_NREG,
  parameter int unsigned DW   = CRTC_DW,
  parameter int unsigned IW   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IW-1:0]      wr_idx,
  input  logic [DW-1:0]      wr_data,
  output logic [NREG*DW-1:0] regs_flat,
  output logic               prot_on
);
  localparam int unsigned PROT_POS = IX_VCTL*DW + VCTL_PROT_BIT;

  assign prot_on = regs_flat[PROT_POS];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic          hit;
    logic          en;
    logic [DW-1:0] d_r;
    logic [DW-1:0] q_r;

    assign hit = wr_en && (wr_idx == IW'(i));

    if (i == IX_OVF) begin : g_ovf
      // line-compare bit 8 escapes protection
      always_comb begin
        en  = hit;
        d_r = q_r;
        if (prot_on) d_r[4] = wr_data[4];
        else         d_r    = wr_data;
      end
    end else if (i <= IX_PROT_LAST) begin : g_prot
      always_comb begin
        en  = hit && !prot_on;
        d_r = wr_data;
      end
    end else begin : g_free
      always_comb begin
        en  = hit;
        d_r = wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q_r <= '0;
      else if (en) q_r <= d_r;
    end

    assign regs_flat[i*DW +: DW] = q_r;
  end
endmodule

// File: rtl/crtc_vfield_asm.sv
module crtc_vfield_asm
  import crtc_pkg::*;
#(
  parameter int unsigned DW = CRTC_DW
) (
  input  logic [DW-1:0]   r_vtot,
  input  logic [DW-1:0]   r_ovf,
  input  logic [1:0]      r_msl_hi,
  input  logic [DW-1:0]   r_vrs,
  input  logic [DW-1:0]   r_vde,
  input  logic [DW-1:0]   r_vbs,
  input  logic [DW-1:0]   r_lcmp,
  input  logic [5:0]      r_csa,
  input  logic [6:0]      r_csb,
  input  logic [DW-1:0]   r_sa_hi,
  input  logic [DW-1:0]   r_sa_lo,
  input  logic [DW-1:0]   r_ca_hi,
  input  logic [DW-1:0]   r_ca_lo,
  output crtc_vwide_t     vw,
  output logic [2*DW-1:0] disp_start,
  output logic [2*DW-1:0] cursor_addr,
  output logic [4:0]      cursor_first,
  output logic [4:0]      cursor_last,
  output logic            cursor_off,
  output logic [1:0]      cursor_skew
);
  always_comb begin
    vw.vtot = {r_ovf[5], r_ovf[0], r_vtot};
    vw.vde  = {r_ovf[6], r_ovf[1], r_vde};
    vw.vrs  = {r_ovf[7], r_ovf[2], r_vrs};
    vw.vbs  = {r_msl_hi[0], r_ovf[3], r_vbs};
    vw.lcmp = {r_msl_hi[1], r_ovf[4], r_lcmp};
  end

  assign disp_start   = {r_sa_hi, r_sa_lo};
  assign cursor_addr  = {r_ca_hi, r_ca_lo};
  assign cursor_first = r_csa[4:0];
  assign cursor_off   = r_csa[5];
  assign cursor_last  = r_csb[4:0];
  assign cursor_skew  = r_csb[6:5];
endmodule

// File: rtl/crtc_vrint.sv
module crtc_vrint (
  input  logic clk,
  input  logic rst_n,
  input  logic vr_in,
  input  logic clr_req,
  input  logic irq_mask,
  output logic irq
);
  logic vr_prev_q;
  logic pend_q;
  logic pend_d;
  logic pend_en;

  always_comb begin
    pend_en = clr_req || (vr_in && !vr_prev_q);
    pend_d  = !clr_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vr_prev_q <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      vr_prev_q <= vr_in;
      if (pend_en) pend_q <= pend_d;
    end
  end

  assign irq = pend_q && !irq_mask;
endmodule

// File: rtl/crtc_regbank.sv
module crtc_regbank
  import crtc_pkg::*;
#(
  parameter int unsigned NREG = CRTC_NREG
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_we,
  input  logic [CRTC_DW-1:0]   bus_wdata,
  output logic [CRTC_DW-1:0]   bus_rdata,
  input  logic                 vretrace_in,
  output logic                 vr_irq,
  output logic [CRTC_DW+1:0]   vert_total,
  output logic [CRTC_DW+1:0]   vert_disp_end,
  output logic [CRTC_DW+1:0]   vert_rtr_start,
  output logic [CRTC_DW+1:0]   vert_blank_start,
  output logic [CRTC_DW+1:0]   line_cmp,
  output logic [2*CRTC_DW-1:0] disp_start,
  output logic [2*CRTC_DW-1:0] cursor_addr,
  output logic [4:0]           cursor_first,
  output logic [4:0]           cursor_last,
  output logic                 cursor_off,
  output logic [1:0]           cursor_skew
);
  localparam int unsigned DW = CRTC_DW;
  localparam int unsigned IW = CRTC_DW;

  logic [1:0]         rst_sync_q;
  logic               rst_sync_n;
  logic [IW-1:0]      idx_q;
  logic [IW-1:0]      idx_d;
  logic               idx_en;
  logic [NREG*DW-1:0] regs_flat;
  logic               prot_on;
  logic               irq_dis;
  logic               vctl_clr;
  logic [DW-1:0]      rd_reg;
  crtc_vwide_t        vw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  always_comb begin
    idx_en = bus_we && !bus_sel;
    idx_d  = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  crtc_reg_store #(.NREG(NREG), .DW(DW), .IW(IW)) u_store (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (bus_we && bus_sel),
    .wr_idx   (idx_q),
    .wr_data  (bus_wdata),
    .regs_flat(regs_flat),
    .prot_on  (prot_on)
  );

  always_comb begin
    rd_reg = '0;
    for (int i = 0; i < NREG; i++)
      if (idx_q == IW'(i)) rd_reg = regs_flat[i*DW +: DW];
  end
  assign bus_rdata = bus_sel ? rd_reg : idx_q;

  assign irq_dis  = regs_flat[IX_VCTL*DW + VCTL_MASK_BIT];
  assign vctl_clr = bus_we && bus_sel && (idx_q == IW'(IX_VCTL)) && !bus_wdata[VCTL_CLR_BIT];

  crtc_vrint u_vrint (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .vr_in   (vretrace_in),
    .clr_req (vctl_clr),
    .irq_mask(irq_dis),
    .irq     (vr_irq)
  );

  crtc_vfield_asm #(.DW(DW)) u_asm (
    .r_vtot      (regs_flat[IX_VTOT*DW +: DW]),
    .r_ovf       (regs_flat[IX_OVF*DW +: DW]),
    .r_msl_hi    (regs_flat[IX_MSL*DW+5 +: 2]),
    .r_vrs       (regs_flat[IX_VRS*DW +: DW]),
    .r_vde       (regs_flat[IX_VDE*DW +: DW]),
    .r_vbs       (regs_flat[IX_VBS*DW +: DW]),
    .r_lcmp      (regs_flat[IX_LCMP*DW +: DW]),
    .r_csa       (regs_flat[IX_CSHAPE_A*DW +: 6]),
    .r_csb       (regs_flat[IX_CSHAPE_B*DW +: 7]),
    .r_sa_hi     (regs_flat[IX_SADDR_HI*DW +: DW]),
    .r_sa_lo     (regs_flat[IX_SADDR_LO*DW +: DW]),
    .r_ca_hi     (regs_flat[IX_CADDR_HI*DW +: DW]),
    .r_ca_lo     (regs_flat[IX_CADDR_LO*DW +: DW]),
    .vw          (vw),
    .disp_start  (disp_start),
    .cursor_addr (cursor_addr),
    .cursor_first(cursor_first),
    .cursor_last (cursor_last),
    .cursor_off  (cursor_off),
    .cursor_skew (cursor_skew)
  );

  assign vert_total       = vw.vtot;
  assign vert_disp_end    = vw.vde;
  assign vert_rtr_start   = vw.vrs;
  assign vert_blank_start = vw.vbs;
  assign line_cmp         = vw.lcmp;
endmodule

// File: rtl/crtc_regbank_chk.sv
module crtc_regbank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_sel,
  input logic       bus_we,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic [7:0] idx_q,
  input logic       vretrace_in,
  input logic       vr_irq,
  input logic       prot_on,
  input logic       irq_dis,
  input logic [9:0] vert_total,
  input logic       lcmp_b8
);
  logic wr_vctl;
  assign wr_vctl = bus_we && bus_sel && (idx_q == 8'h11);

  // R1
  idx_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !bus_sel) |=> (idx_q == $past(bus_wdata)));

  // R3
  high_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && (idx_q > 8'h18)) |-> (bus_rdata == 8'h00));

  // R4
  prot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_on && bus_we && bus_sel && (idx_q == 8'h06)) |=> $stable(vert_total));

  // R4
  lcmp_b8_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_sel && (idx_q == 8'h07)) |=> (lcmp_b8 == $past(bus_wdata[4])));

  // R9
  vr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(vretrace_in) && !wr_vctl && !irq_dis) |=> vr_irq);

  // R10
  vr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vctl && !bus_wdata[4]) |=> !vr_irq);
endmodule

bind crtc_regbank crtc_regbank_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .bus_sel    (bus_sel),
  .bus_we     (bus_we),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .idx_q      (idx_q),
  .vretrace_in(vretrace_in),
  .vr_irq     (vr_irq),
  .prot_on    (prot_on),
  .irq_dis    (irq_dis),
  .vert_total (vert_total),
  .lcmp_b8    (line_cmp[8])
);

// File: tb/crtc_regbank_bench.sv
`timescale 1ns/1ps
module crtc_regbank_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       vretrace_in = 1'b0;
  logic       vr_irq;
  logic [9:0] vert_total, vert_disp_end, vert_rtr_start, vert_blank_start, line_cmp;
  logic [15:0] disp_start, cursor_addr;
  logic [4:0] cursor_first, cursor_last;
  logic       cursor_off;
  logic [1:0] cursor_skew;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  crtc_regbank u_crtc_regbank (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .vretrace_in(vretrace_in),
    .vr_irq(vr_irq), .vert_total(vert_total), .vert_disp_end(vert_disp_end),
    .vert_rtr_start(vert_rtr_start), .vert_blank_start(vert_blank_start),
    .line_cmp(line_cmp), .disp_start(disp_start), .cursor_addr(cursor_addr),
    .cursor_first(cursor_first), .cursor_last(cursor_last),
    .cursor_off(cursor_off), .cursor_skew(cursor_skew)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic sel, input logic [7:0] d);
    bus_sel = sel; bus_we = 1'b1; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] ix, input logic [7:0] d);
    bus_wr(1'b0, ix);
    bus_wr(1'b1, d);
  endtask

  task automatic rd_reg(input logic [7:0] ix, output logic [7:0] d);
    bus_wr(1'b0, ix);
    bus_sel = 1'b1;
    #1 d = bus_rdata;
  endtask

  function automatic logic [7:0] pat(input int i, input int p);
    logic [7:0] v;
    v = 8'(i*29 + p*71 + 3);
    if (i == 'h11) v = v & 8'h4F;
    return v;
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] rv;
    logic [7:0] r6, r7, r9, r10, r12, r15, r18;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    bus_sel = 1'b0; #1 chk("R11 index", {8'h0, bus_rdata}, 16'h0);
    chk("R11 irq", {15'h0, vr_irq}, 16'h0);
    for (int i = 0; i < 25; i++) begin
      rd_reg(8'(i), rv);
      chk("R11 reg", {8'h0, rv}, 16'h0);
    end

    // R1 index sweep
    for (int i = 0; i < 256; i++) begin
      bus_wr(1'b0, 8'(i));
      bus_sel = 1'b0; #1 chk("R1 index readback", {8'h0, bus_rdata}, 16'(i));
    end

    // R2 data port sweep, two patterns
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < 25; i++) wr_reg(8'(i), pat(i, p));
      for (int i = 0; i < 25; i++) begin
        rd_reg(8'(i), rv);
        chk("R2 reg readback", {8'h0, rv}, {8'h0, pat(i, p)});
      end
    end

    // R3 indices above the top are dropped and read as zero
    for (int i = 'h19; i < 256; i++) begin
      wr_reg(8'(i), 8'hA5);
      bus_sel = 1'b1; #1 chk("R3 high read zero", {8'h0, bus_rdata}, 16'h0);
    end
    for (int i = 0; i < 25; i++) begin
      rd_reg(8'(i), rv);
      chk("R3 no side write", {8'h0, rv}, {8'h0, pat(i, 1)});
    end

    // R4 write protection
    for (int i = 0; i < 8; i++) wr_reg(8'(i), 8'h10 + 8'(i));
    wr_reg(8'h07, 8'h07);
    wr_reg(8'h11, 8'h80);
    for (int i = 0; i < 8; i++) wr_reg(8'(i), 8'hF8 - 8'(i) + 8'(i == 7 ? 7 : 0));
    for (int i = 0; i < 7; i++) begin
      rd_reg(8'(i), rv);
      chk("R4 protected reg held", {8'h0, rv}, 16'h10 + 16'(i));
    end
    rd_reg(8'h07, rv);
    chk("R4 overflow bit4 only", {8'h0, rv}, 16'h0017);
    chk("R4 line_cmp bit8", {15'h0, line_cmp[8]}, 16'h1);
    wr_reg(8'h09, 8'h3C);
    rd_reg(8'h09, rv);
    chk("R4 unprotected index", {8'h0, rv}, 16'h003C);
    wr_reg(8'h11, 8'h00);
    wr_reg(8'h03, 8'h5C);
    rd_reg(8'h03, rv);
    chk("R4 protection lifted", {8'h0, rv}, 16'h005C);

    // R5 R6 wide field sweep over every overflow value
    for (int k = 0; k < 256; k++) begin
      r6 = 8'(k*3 + 1); r7 = 8'(k); r9 = 8'(k*5) ^ 8'h5A; r10 = ~8'(k);
      r12 = 8'(k + 7); r15 = 8'(k*11); r18 = 8'(k*13);
      wr_reg(8'h06, r6); wr_reg(8'h07, r7); wr_reg(8'h09, r9); wr_reg(8'h10, r10);
      wr_reg(8'h12, r12); wr_reg(8'h15, r15); wr_reg(8'h18, r18);
      #1;
      chk("R5 vert_total", 16'(vert_total), 16'(r6) + 16'(r7[0])*256 + 16'(r7[5])*512);
      chk("R5 vert_disp_end", 16'(vert_disp_end), 16'(r12) + 16'(r7[1])*256 + 16'(r7[6])*512);
      chk("R5 vert_rtr_start", 16'(vert_rtr_start), 16'(r10) + 16'(r7[2])*256 + 16'(r7[7])*512);
      chk("R6 line_cmp", 16'(line_cmp), 16'(r18) + 16'(r7[4])*256 + 16'(r9[6])*512);
      chk("R6 vert_blank_start", 16'(vert_blank_start), 16'(r15) + 16'(r7[3])*256 + 16'(r9[5])*512);
    end

    // R7 addresses
    for (int k = 0; k < 64; k++) begin
      wr_reg(8'h0C, 8'(k*7)); wr_reg(8'h0D, 8'(k*19 + 1));
      wr_reg(8'h0E, 8'(255 - k)); wr_reg(8'h0F, 8'(k*3));
      #1;
      chk("R7 disp_start", disp_start, 16'(k*7 % 256)*256 + 16'((k*19 + 1) % 256));
      chk("R7 cursor_addr", cursor_addr, 16'(255 - k)*256 + 16'(k*3));
    end

    // R8 cursor shape fields
    for (int k = 0; k < 256; k++) begin
      wr_reg(8'h0A, 8'(k)); wr_reg(8'h0B, 8'(255 - k));
      #1;
      chk("R8 cursor_first", 16'(cursor_first), 16'(k % 32));
      chk("R8 cursor_off", 16'(cursor_off), 16'((k / 32) % 2));
      chk("R8 cursor_last", 16'(cursor_last), 16'((255 - k) % 32));
      chk("R8 cursor_skew", 16'(cursor_skew), 16'(((255 - k) / 32) % 4));
    end

    // R9 R10 interrupt
    wr_reg(8'h11, 8'h00);
    vretrace_in = 1'b1; @(posedge clk); @(negedge clk);
    chk("R9 rise sets irq", {15'h0, vr_irq}, 16'h1);
    wr_reg(8'h11, 8'h10);
    chk("R10 bit4 set keeps", {15'h0, vr_irq}, 16'h1);
    wr_reg(8'h11, 8'h00);
    chk("R10 clear", {15'h0, vr_irq}, 16'h0);
    repeat (3) @(negedge clk);
    chk("R9 level does not re-arm", {15'h0, vr_irq}, 16'h0);
    vretrace_in = 1'b0;
    wr_reg(8'h11, 8'h30);
    vretrace_in = 1'b1; @(posedge clk); @(negedge clk);
    vretrace_in = 1'b0;
    chk("R9 masked", {15'h0, vr_irq}, 16'h0);
    wr_reg(8'h11, 8'h10);
    chk("R9 unmask shows pending", {15'h0, vr_irq}, 16'h1);
    wr_reg(8'h11, 8'h00);
    chk("R10 clear after unmask", {15'h0, vr_irq}, 16'h0);
    bus_wr(1'b0, 8'h11);
    vretrace_in = 1'b1;
    bus_wr(1'b1, 8'h00);
    chk("R10 clear beats edge", {15'h0, vr_irq}, 16'h0);
    vretrace_in = 1'b0;
    @(negedge clk);
    vretrace_in = 1'b1; @(posedge clk); @(negedge clk);
    chk("R9 later edge sets", {15'h0, vr_irq}, 16'h1);

    finish_run();
  end
endmodule